// File: doc/BRIEF.md
# Superframe Line Framer

This block assembles the serial transmit stream of a two-channel-plus-signalling digital subscriber line. The stream is built from 240-bit frames, and eight consecutive frames make up one superframe. Each frame starts with an 18-bit sync pattern. Next come twelve 18-bit payload groups, each made of two 8-bit bearer octets and a 2-bit signalling pair. The frame ends with six overhead bits. The first frame of every superframe carries the bitwise complement of the sync pattern, which lets the far end locate superframe boundaries.

Payload groups arrive over a single ready/valid handshake, one group per transfer. The overhead content comes from four 12-bit fields: two operations-channel messages, a control/status word and a CRC word, the CRC being computed by a neighbouring block. The block captures all four fields once at the start of each superframe and spreads those 48 bits over the six overhead slots of the eight frames. The block emits one bit for each cycle in which the bit-clock enable is high. Frame-start and superframe-start strobes accompany the stream. When a payload group is missing at the moment it is due, the block sends idle ones in its place and flags the event.

Top module: `sf_line_framer`

## Requirements
- R1: Each frame is 240 bit periods. Positions 0-17 carry sync, 18-233 carry payload and 234-239 carry overhead. `frame_start_o` is high exactly while position 0 is on `line_bit_o`.
- R2: Eight frames, numbered 0 to 7, make a superframe. `sf_start_o` is high only while position 0 of frame 0 is shown.
- R3: Frame 0 sends the complement of `SYNC_WORD` and frames 1-7 send `SYNC_WORD`, most significant bit first.
- R4: A payload group is sent as `b1_i` bit 7 down to bit 0, then `b2_i` bit 7 down to bit 0, then `d_i` bit 1 then bit 0.
- R5: `data_ready_o` is high only in a cycle where `bit_en_i` is high and the bit about to be shown is the first bit of a payload group (positions 18, 36, ..., 216). A group transfers when `data_valid_i` and `data_ready_o` are both high. `data_valid_i` has no effect at any other time.
- R6: The overhead fields are captured on the bit-enable cycle that starts frame 0. The 48-bit word {eoc_a_i, eoc_b_i, ctrl_i, crc_i} is sent most significant bit first, six bits per frame, in frames 0 to 7. Input changes later in the superframe take effect only at the next superframe.
- R7: If `data_valid_i` is low when a group is due, that group's 18 bits are all ones. `underflow_o` is high only while the first bit of that idle group is shown.
- R8: `line_bit_o`, `frame_start_o`, `sf_start_o` and `underflow_o` update only on cycles with `bit_en_i` high and hold between them.
- R9: Reset leaves `line_bit_o` high and the strobes and `underflow_o` low. The first enabled bit after reset is position 0 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | Line bit-clock enable, one pulse per line bit |
| data_valid_i | input | 1 | Payload group valid |
| data_ready_o | output | 1 | Payload group accepted this cycle |
| b1_i | input | 8 | First bearer octet |
| b2_i | input | 8 | Second bearer octet |
| d_i | input | 2 | Signalling pair |
| eoc_a_i | input | 12 | First operations-channel message |
| eoc_b_i | input | 12 | Second operations-channel message |
| ctrl_i | input | 12 | Control/status bits |
| crc_i | input | 12 | CRC from the neighbouring block |
| line_bit_o | output | 1 | Serial line bit |
| frame_start_o | output | 1 | First sync bit of a frame is shown |
| sf_start_o | output | 1 | First sync bit of a superframe is shown |
| underflow_o | output | 1 | First bit of an idle-filled group is shown |

## Verification
A bit or frame counter that slips shows up at the ports within one bit period. The sync word, the payload, the strobes and the expected `data_ready_o` cycle all move to the wrong positions. A wrong superframe counter first shows within one frame, when the complemented sync appears in the wrong frame or fails to appear. A stale or early overhead capture only shows in the overhead slots, six bits per frame, and a mid-superframe input change is needed to expose capture at the wrong time. A shift register that drops or reorders bits corrupts the payload bits that follow within the same 18-bit group. The bench therefore predicts every line bit of three full superframes.

// File: rtl/sf_framer_pkg.sv
package sf_framer_pkg;
  localparam int DEF_SYNC_W  = 18;
  localparam int DEF_B_W     = 8;
  localparam int DEF_D_W     = 2;
  localparam int DEF_N_GRP   = 12;
  localparam int DEF_N_M     = 6;
  localparam int DEF_N_FRM   = 8;
  localparam int DEF_FIELD_W = 12;

  typedef enum logic [1:0] {
    RGN_SYNC = 2'd0,
    RGN_DATA = 2'd1,
    RGN_OH   = 2'd2
  } region_e;
endpackage

// File: rtl/sf_bit_counter.sv
module sf_bit_counter import sf_framer_pkg::*; #(
  parameter int SYNC_W = DEF_SYNC_W,
  parameter int GRP_W  = 2 * DEF_B_W + DEF_D_W,
  parameter int N_GRP  = DEF_N_GRP,
  parameter int N_M    = DEF_N_M,
  parameter int N_FRM  = DEF_N_FRM,
  localparam int FRAME_BITS = SYNC_W + N_GRP * GRP_W + N_M,
  localparam int DATA_END   = SYNC_W + N_GRP * GRP_W,
  localparam int POS_W      = $clog2(FRAME_BITS),
  localparam int FRM_W      = $clog2(N_FRM),
  localparam int OI_W       = $clog2(N_M)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [POS_W-1:0] pos_o,
  output logic [FRM_W-1:0] frame_o,
  output region_e          region_o,
  output logic             grp_start_o,
  output logic [OI_W-1:0]  oh_idx_o
);
  logic [POS_W-1:0] pos_q;
  logic [FRM_W-1:0] frame_q;
  logic             last_bit;

  assign last_bit = (pos_q == POS_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      frame_q <= '0;
    end else if (adv_i) begin
      if (last_bit) begin
        pos_q   <= '0;
        frame_q <= (frame_q == FRM_W'(N_FRM - 1)) ? '0 : frame_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (int'(pos_q) < SYNC_W)        region_o = RGN_SYNC;
    else if (int'(pos_q) < DATA_END) region_o = RGN_DATA;
    else                             region_o = RGN_OH;
    grp_start_o = (region_o == RGN_DATA) && (((int'(pos_q) - SYNC_W) % GRP_W) == 0);
    oh_idx_o    = OI_W'(pos_q - POS_W'(DATA_END));
  end

  assign pos_o   = pos_q;
  assign frame_o = frame_q;

  // R1
  pos_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> pos_q == (($past(pos_q) == POS_W'(FRAME_BITS - 1)) ? '0 : $past(pos_q) + 1'b1));
  // R8
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(pos_q) && $stable(frame_q)));
  // R2
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && last_bit && frame_q == FRM_W'(N_FRM - 1)) |=> frame_q == '0);
endmodule

// File: rtl/sf_group_buffer.sv
module sf_group_buffer #(
  parameter int B_W = 8,
  parameter int D_W = 2,
  localparam int GRP_W = 2 * B_W + D_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           adv_i,
  input  logic           load_i,
  input  logic           shift_i,
  input  logic           valid_i,
  input  logic [B_W-1:0] b1_i,
  input  logic [B_W-1:0] b2_i,
  input  logic [D_W-1:0] d_i,
  output logic           ready_o,
  output logic           bit_o,
  output logic           uflow_o
);
  logic [GRP_W-1:0] sh_q;
  logic [GRP_W-1:0] load_word;

  assign load_word = valid_i ? {b1_i, b2_i, d_i} : '1;
  assign ready_o   = adv_i & load_i;
  assign bit_o     = load_i ? load_word[GRP_W-1] : sh_q[GRP_W-1];
  assign uflow_o   = load_i & ~valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sh_q <= '1;
    else if (adv_i && load_i)   sh_q <= load_word << 1;
    else if (adv_i && shift_i)  sh_q <= sh_q << 1;
  end

  // R4
  grp_next_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && load_i && valid_i) |=> sh_q[GRP_W-1] == $past(b1_i[B_W-2]));
  // R7
  grp_idle_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && load_i && !valid_i) |=> &sh_q[GRP_W-1:1]);
endmodule

// File: rtl/sf_overhead_sel.sv
module sf_overhead_sel #(
  parameter int FIELD_W = 12,
  parameter int N_M     = 6,
  parameter int N_FRM   = 8,
  localparam int OH_W   = 4 * FIELD_W,
  localparam int OH_IW  = $clog2(OH_W),
  localparam int FRM_W  = $clog2(N_FRM),
  localparam int OI_W   = $clog2(N_M)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               latch_i,
  input  logic [FIELD_W-1:0] eoc_a_i,
  input  logic [FIELD_W-1:0] eoc_b_i,
  input  logic [FIELD_W-1:0] ctrl_i,
  input  logic [FIELD_W-1:0] crc_i,
  input  logic [FRM_W-1:0]   frame_i,
  input  logic [OI_W-1:0]    idx_i,
  output logic               bit_o
);
  logic [OH_W-1:0]  oh_q;
  logic [OH_IW-1:0] sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      oh_q <= '0;
    else if (latch_i) oh_q <= {eoc_a_i, eoc_b_i, ctrl_i, crc_i};
  end

  // superframe word MSB first, N_M bits per frame
  assign sel   = OH_IW'(OH_W - 1) - (OH_IW'(frame_i) * OH_IW'(N_M) + OH_IW'(idx_i));
  assign bit_o = oh_q[sel];

  // R6
  oh_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(oh_q));
  // R6
  oh_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> oh_q == $past({eoc_a_i, eoc_b_i, ctrl_i, crc_i}));
endmodule

// File: rtl/sf_line_framer.sv
module sf_line_framer import sf_framer_pkg::*; #(
  parameter int SYNC_W  = DEF_SYNC_W,
  parameter int B_W     = DEF_B_W,
  parameter int D_W     = DEF_D_W,
  parameter int N_GRP   = DEF_N_GRP,
  parameter int N_M     = DEF_N_M,
  parameter int N_FRM   = DEF_N_FRM,
  parameter int FIELD_W = DEF_FIELD_W,
  parameter logic [SYNC_W-1:0] SYNC_WORD = SYNC_W'(18'h2C6B1),
  localparam int GRP_W      = 2 * B_W + D_W,
  localparam int FRAME_BITS = SYNC_W + N_GRP * GRP_W + N_M,
  localparam int POS_W      = $clog2(FRAME_BITS),
  localparam int FRM_W      = $clog2(N_FRM),
  localparam int OI_W       = $clog2(N_M),
  localparam int SI_W       = $clog2(SYNC_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               data_valid_i,
  output logic               data_ready_o,
  input  logic [B_W-1:0]     b1_i,
  input  logic [B_W-1:0]     b2_i,
  input  logic [D_W-1:0]     d_i,
  input  logic [FIELD_W-1:0] eoc_a_i,
  input  logic [FIELD_W-1:0] eoc_b_i,
  input  logic [FIELD_W-1:0] ctrl_i,
  input  logic [FIELD_W-1:0] crc_i,
  output logic               line_bit_o,
  output logic               frame_start_o,
  output logic               sf_start_o,
  output logic               underflow_o
);
  logic [POS_W-1:0]  pos;
  logic [FRM_W-1:0]  frame;
  region_e           region;
  logic              grp_start;
  logic [OI_W-1:0]   oh_idx;
  logic              grp_bit, grp_uflow, oh_bit;
  logic              at_sf_start, at_frame_start;
  logic [SYNC_W-1:0] sync_cur;
  logic [SI_W-1:0]   sync_sel;
  logic              next_bit;

  sf_bit_counter #(
    .SYNC_W(SYNC_W), .GRP_W(GRP_W), .N_GRP(N_GRP), .N_M(N_M), .N_FRM(N_FRM)
  ) u_cnt (
    .clk_i, .rst_ni, .adv_i(bit_en_i),
    .pos_o(pos), .frame_o(frame), .region_o(region),
    .grp_start_o(grp_start), .oh_idx_o(oh_idx)
  );

  sf_group_buffer #(.B_W(B_W), .D_W(D_W)) u_grp (
    .clk_i, .rst_ni, .adv_i(bit_en_i),
    .load_i(grp_start), .shift_i(region == RGN_DATA && !grp_start),
    .valid_i(data_valid_i), .b1_i, .b2_i, .d_i,
    .ready_o(data_ready_o), .bit_o(grp_bit), .uflow_o(grp_uflow)
  );

  assign at_frame_start = (pos == '0);
  assign at_sf_start    = at_frame_start && (frame == '0);

  sf_overhead_sel #(.FIELD_W(FIELD_W), .N_M(N_M), .N_FRM(N_FRM)) u_oh (
    .clk_i, .rst_ni, .latch_i(bit_en_i && at_sf_start),
    .eoc_a_i, .eoc_b_i, .ctrl_i, .crc_i,
    .frame_i(frame), .idx_i(oh_idx), .bit_o(oh_bit)
  );

  assign sync_cur = (frame == '0) ? ~SYNC_WORD : SYNC_WORD;
  assign sync_sel = SI_W'(SYNC_W - 1) - SI_W'(pos);

  always_comb begin
    unique case (region)
      RGN_SYNC: next_bit = sync_cur[sync_sel];
      RGN_DATA: next_bit = grp_bit;
      default:  next_bit = oh_bit;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_bit_o    <= 1'b1;
      frame_start_o <= 1'b0;
      sf_start_o    <= 1'b0;
      underflow_o   <= 1'b0;
    end else if (bit_en_i) begin
      line_bit_o    <= next_bit;
      frame_start_o <= at_frame_start;
      sf_start_o    <= at_sf_start;
      underflow_o   <= grp_uflow;
    end
  end

  // R2
  sf_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sf_start_o |-> frame_start_o);
  // R7
  uflow_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> line_bit_o);
  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(line_bit_o) && $stable(frame_start_o) && $stable(underflow_o)));
  // R3
  sync_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> line_bit_o == (sf_start_o ? ~SYNC_WORD[SYNC_W-1] : SYNC_WORD[SYNC_W-1]));
  // R5
  ready_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> (region == RGN_DATA && !frame_start_o));
endmodule

// File: tb/tb_sf_line_framer.sv
module tb_sf_line_framer;
  localparam logic [17:0] SYNC = 18'h2C6B1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [7:0]  b1 = '0, b2 = '0;
  logic [1:0]  d = '0;
  logic [11:0] eoc_a = '0, eoc_b = '0, ctrl = '0, crc = '0;
  logic        line_bit, fs, sfs, uflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int          m_pos = 0, m_frame = 0, m_gidx = 0;
  logic [47:0] m_oh = '0;
  logic [17:0] m_word = '1;

  always #5 clk = ~clk;

  sf_line_framer dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .data_valid_i(valid),
    .data_ready_o(ready), .b1_i(b1), .b2_i(b2), .d_i(d),
    .eoc_a_i(eoc_a), .eoc_b_i(eoc_b), .ctrl_i(ctrl), .crc_i(crc),
    .line_bit_o(line_bit), .frame_start_o(fs), .sf_start_o(sfs), .underflow_o(uflow)
  );

  function automatic logic [17:0] gen(int g);
    return {8'(g * 37 + 5), 8'(g ^ 8'hA5), 2'(g)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (frame %0d pos %0d)", req, act, exp, m_frame, m_pos);
    end
  endtask

  // one line bit: enable cycle followed by one idle cycle
  task automatic do_bit(bit starve);
    bit          start;
    logic        e;
    logic [17:0] s;
    int          off;
    start = (m_pos >= 18) && (m_pos < 234) && (((m_pos - 18) % 18) == 0);
    bit_en = 1'b1;
    if (start) begin
      valid = !starve;
      {b1, b2, d} = gen(m_gidx);
    end else begin
      valid = 1'b1;                  // must be ignored off-slot
      {b1, b2, d} = gen(m_gidx + 100);
    end
    if (m_pos == 0 && m_frame == 0) m_oh = {eoc_a, eoc_b, ctrl, crc};
    #1;
    chk("R5 ready", 32'(ready), 32'(start));
    if (m_pos < 18) begin
      s = (m_frame == 0) ? ~SYNC : SYNC;
      e = s[17 - m_pos];
    end else if (m_pos < 234) begin
      off = (m_pos - 18) % 18;
      if (start) begin
        m_word = starve ? 18'h3FFFF : gen(m_gidx);
        if (!starve) m_gidx++;
      end
      e = m_word[17 - off];
    end else begin
      e = m_oh[47 - (m_frame * 6 + m_pos - 234)];
    end
    @(posedge clk);
    #2;
    bit_en = 1'b0;
    valid = 1'b0;
    if (m_pos < 18)       chk("R3 sync bit", 32'(line_bit), 32'(e));
    else if (m_pos < 234) chk(starve ? "R7 idle bit" : "R4 data bit", 32'(line_bit), 32'(e));
    else                  chk("R6 overhead bit", 32'(line_bit), 32'(e));
    chk("R1 frame_start", 32'(fs), 32'(m_pos == 0));
    chk("R2 sf_start", 32'(sfs), 32'(m_pos == 0 && m_frame == 0));
    chk("R7 underflow", 32'(uflow), 32'(start && starve));
    @(posedge clk);
    #2;
    chk("R8 hold line", 32'(line_bit), 32'(e));
    chk("R8 hold strobe", 32'(fs), 32'(m_pos == 0));
    if (m_pos == 239) begin
      m_pos = 0;
      m_frame = (m_frame + 1) % 8;
    end else begin
      m_pos++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R9 reset line", 32'(line_bit), 32'd1);
    chk("R9 reset frame_start", 32'(fs), 32'd0);
    chk("R9 reset sf_start", 32'(sfs), 32'd0);
    chk("R9 reset underflow", 32'(uflow), 32'd0);
    chk("R9 reset ready", 32'(ready), 32'd0);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
  endtask

  // full superframe; optional starvation and mid-superframe overhead change
  task automatic t_superframe(bit starve_mode, bit change_mid,
                              logic [11:0] a, logic [11:0] b, logic [11:0] c, logic [11:0] r);
    eoc_a = a; eoc_b = b; ctrl = c; crc = r;
    for (int i = 0; i < 1920; i++) begin
      bit st;
      if (change_mid && i == 960) begin
        eoc_a = ~a; eoc_b = ~b; ctrl = ~c; crc = ~r;   // R6: latched copy stays
      end
      st = starve_mode && (m_frame == 3 || (m_frame == 5 && m_pos >= 90 && m_pos < 108));
      do_bit(st);
    end
  endtask

  initial begin
    t_reset();
    t_superframe(1'b0, 1'b0, 12'hA5C, 12'h3E1, 12'hF0F, 12'h6B2);
    t_superframe(1'b0, 1'b1, 12'h123, 12'hFED, 12'h0F0, 12'h9A7);
    t_superframe(1'b1, 1'b0, 12'h5A5, 12'hC3C, 12'h801, 12'h17E);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule